// File: doc/BRIEF.md
# Watchdog Timer with Configurable External Reset Pulse

This block is a watchdog timer on a simple register bus. A down counter moves one step on each pulse of a 1 MHz tick-enable input. Software keeps the system alive by writing a fixed key value to a restart register. If the counter runs out while the watchdog is enabled, the block drives an external reset pulse on a pad. It can also raise a one-cycle internal reset request.

The pulse length, its active level and the pad drive style are set in a pulse-configuration register. The pulse length field can be written directly. The active level and the drive style can only be changed by writing one of four key values into the top byte of that register. Any other top byte leaves both settings unchanged. The length field is still taken from every write. The pad is modelled as an output value plus an output enable, so a push-pull or an open-drain driver can be built from it.

The register map uses byte offsets:

| Offset | Register |
|--------|----------|
| 0x00 | counter (read-only) |
| 0x04 | reload value |
| 0x08 | restart (reads 0) |
| 0x0C | control |
| 0x18 | pulse configuration |

Top module: `wdt_pulse_ctrl`

## Requirements
- R1: After reset, the pulse configuration reads 0x000000FF. This means a length field of 0xFF, active-low level and open-drain drive. Control reads 0, the reload and counter registers read RELOAD_RST, pad_out is 1 and pad_oe is 0.
- R2: Every write to offset 0x18 loads bits 19:0 into the length field. Bits 29:20 of that register always read as zero.
- R3: A write to 0x18 with top byte 0xA5 sets the active-high level. Top byte 0x5A sets the active-low level. The level reads back in bit 31, where 1 means active high.
- R4: A write to 0x18 with top byte 0xA8 selects push-pull drive. Top byte 0x8A selects open-drain drive. The drive style reads back in bit 30, where 1 means push-pull.
- R5: A write to 0x18 with any other top byte leaves both bit 31 and bit 30 unchanged.
- R6: Control bit 0 enables the watchdog. While it is enabled, the counter at 0x00 decreases by one on each cycle with tick high. While it is disabled, the counter holds its value.
- R7: Writing exactly 0x00004755 to 0x08 reloads the counter from the reload register at 0x04. Any other value has no effect. A restart in the same cycle as a would-be expiry wins, and no expiry happens.
- R8: Expiry is a cycle where the watchdog is enabled, tick is high and the counter is zero. On expiry the counter reloads, and from the next cycle the pulse is asserted for exactly length+1 tick cycles.
- R9: rst_req is high for one cycle, the cycle after an expiry, only when control bit 1 was set at that expiry.
- R10: In push-pull mode pad_oe is 1, and pad_out is the active level during the pulse and the inverse level otherwise. In open-drain mode pad_oe is 1 only during the pulse.
- R11: The pulse length is captured at expiry, so a length write during a pulse does not change that pulse. An expiry during a pulse restarts it at the current length+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1m | input | 1 | One-cycle time-base enable at 1 MHz |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_out | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output enable |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
A restart write and a counter expiry can fall in the same cycle. Restart must win, so the counter reloads and neither a pulse nor a reset request follows. The bench provokes this by setting the reload value to zero and ticking every cycle, so the counter is at zero on each tick, and then issuing the restart key in a tick cycle. A behavioural model, compared on every clock, judges the following pad, request and counter values. A second overlap is also exercised: a length write, or a fresh expiry, arriving while a pulse is still running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_COUNT  = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h04;
  localparam logic [7:0] OFS_KICK   = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_PULSE  = 8'h18;

  localparam logic [31:0] KICK_KEY = 32'h0000_4755;

  localparam logic [7:0] KEY_LEVEL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_LEVEL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL  = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRAIN = 8'h8A;

  typedef struct packed {
    logic level_high;
    logic push_pull;
  } pad_mode_t;

  // New pad mode after a write whose top byte is key
  function automatic pad_mode_t apply_key(pad_mode_t cur, logic [7:0] key);
    pad_mode_t nxt;
    nxt = cur;
    case (key)
      KEY_LEVEL_HIGH: nxt.level_high = 1'b1;
      KEY_LEVEL_LOW:  nxt.level_high = 1'b0;
      KEY_PUSH_PULL:  nxt.push_pull  = 1'b1;
      KEY_OPEN_DRAIN: nxt.push_pull  = 1'b0;
      default:        nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic pad_level(logic active, logic level_high);
    return active ? level_high : ~level_high;
  endfunction

  function automatic logic pad_enable(logic active, logic push_pull);
    return push_pull | active;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter int PW_W       = 20,
  parameter logic [CNT_W-1:0] RELOAD_RST = '0,
  parameter logic [PW_W-1:0]  PW_RST     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [CNT_W-1:0]  reload,
  output logic              ctrl_en,
  output logic              ctrl_sysrst,
  output logic [PW_W-1:0]   pulse_len,
  output pad_mode_t         mode,
  output logic              kick,
  output logic              pulse_wr
);
  logic reload_wr, ctrl_wr;

  assign reload_wr = wr_en && (addr == ADDR_W'(OFS_RELOAD));
  assign ctrl_wr   = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign pulse_wr  = wr_en && (addr == ADDR_W'(OFS_PULSE));
  assign kick      = wr_en && (addr == ADDR_W'(OFS_KICK)) && (wdata == KICK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload      <= RELOAD_RST;
      ctrl_en     <= 1'b0;
      ctrl_sysrst <= 1'b0;
      pulse_len   <= PW_RST;
      mode        <= '{level_high: 1'b0, push_pull: 1'b0};
    end else begin
      if (reload_wr) reload <= wdata[CNT_W-1:0];
      if (ctrl_wr) begin
        ctrl_en     <= wdata[0];
        ctrl_sysrst <= wdata[1];
      end
      if (pulse_wr) begin
        pulse_len <= wdata[PW_W-1:0];
        mode      <= apply_key(mode, wdata[31:24]);
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = enable && tick && at_zero && !kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= RELOAD_RST;
    else if (kick)            count <= reload;
    else if (enable && tick)  count <= at_zero ? reload : count - 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import wdt_pkg::*;
#(
  parameter int PW_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            expire,
  input  logic            sysrst_en,
  input  logic [PW_W-1:0] pulse_len,
  input  pad_mode_t       mode,
  output logic            pulse_active,
  output logic            rst_req,
  output logic            pad_out,
  output logic            pad_oe
);
  logic [PW_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_active <= 1'b0;
      remain       <= '0;
      rst_req      <= 1'b0;
    end else begin
      rst_req <= expire && sysrst_en;
      if (expire) begin
        pulse_active <= 1'b1;
        remain       <= pulse_len;
      end else if (tick && pulse_active) begin
        if (remain == '0) pulse_active <= 1'b0;
        else              remain <= remain - 1'b1;
      end
    end
  end

  assign pad_out = pad_level(pulse_active, mode.level_high);
  assign pad_oe  = pad_enable(pulse_active, mode.push_pull);
endmodule

// File: rtl/wdt_pulse_ctrl.sv
module wdt_pulse_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PW_W   = 20,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_1000,
  parameter logic [PW_W-1:0]  PW_RST     = 20'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1m,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              rst_req
);
  localparam int DATA_W = 32;

  logic [CNT_W-1:0] reload, count;
  logic [PW_W-1:0]  pulse_len;
  logic             ctrl_en, ctrl_sysrst, kick, pulse_wr, expire, pulse_active;
  pad_mode_t        mode;
  logic             level_high, drive_pp;

  assign level_high = mode.level_high;
  assign drive_pp   = mode.push_pull;

  wdt_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PW_W(PW_W),
    .RELOAD_RST(RELOAD_RST), .PW_RST(PW_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .reload(reload), .ctrl_en(ctrl_en), .ctrl_sysrst(ctrl_sysrst),
    .pulse_len(pulse_len), .mode(mode), .kick(kick), .pulse_wr(pulse_wr)
  );

  wdt_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick_1m), .enable(ctrl_en), .kick(kick),
    .reload(reload), .count(count), .expire(expire)
  );

  wdt_pulse #(.PW_W(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick_1m), .expire(expire),
    .sysrst_en(ctrl_sysrst), .pulse_len(pulse_len), .mode(mode),
    .pulse_active(pulse_active), .rst_req(rst_req),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_COUNT)) begin
      bus_rdata[CNT_W-1:0] = count;
    end else if (bus_addr == ADDR_W'(OFS_RELOAD)) begin
      bus_rdata[CNT_W-1:0] = reload;
    end else if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata[1:0] = {ctrl_sysrst, ctrl_en};
    end else if (bus_addr == ADDR_W'(OFS_PULSE)) begin
      bus_rdata[DATA_W-1]   = level_high;
      bus_rdata[DATA_W-2]   = drive_pp;
      bus_rdata[PW_W-1:0]   = pulse_len;
    end
  end
endmodule

// File: rtl/wdt_pulse_ctrl_chk.sv
module wdt_pulse_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             expire,
  input logic             kick,
  input logic             ctrl_sysrst,
  input logic             rst_req,
  input logic             pulse_active,
  input logic             drive_pp,
  input logic             level_high,
  input logic             pad_oe,
  input logic             pulse_wr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload
);
  AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count == $past(reload)));  // R7
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_wr |=> ($stable(level_high) && $stable(drive_pp)));  // R5
  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pulse_active);  // R8
  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_sysrst) |=> rst_req);  // R9
  AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(expire));  // R9
  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    drive_pp |-> pad_oe);  // R10
  AST_OD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_pp && !pulse_active) |-> !pad_oe);  // R10
endmodule

bind wdt_pulse_ctrl wdt_pulse_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .expire(expire), .kick(kick),
  .ctrl_sysrst(ctrl_sysrst), .rst_req(rst_req), .pulse_active(pulse_active),
  .drive_pp(drive_pp), .level_high(level_high), .pad_oe(pad_oe),
  .pulse_wr(pulse_wr), .count(count), .reload(reload)
);

// File: tb/wdt_pulse_ctrl_bench.sv
module wdt_pulse_ctrl_bench;
  localparam logic [31:0] RLD_RST = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = 8'h18;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pad_out, pad_oe, rst_req;

  int checks = 0;
  int fails = 0;
  bit live = 1'b0;

  always #4 clk = ~clk;

  wdt_pulse_ctrl u_wdt_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_1m(tick), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .rst_req(rst_req)
  );

  // Behavioural reference model
  logic [31:0] m_cnt, m_reload;
  bit m_en, m_sr, m_hi, m_pp, m_req, m_kick, m_exp;
  int m_len, m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = RLD_RST; m_reload = RLD_RST; m_en = 0; m_sr = 0;
      m_len = 255; m_hi = 0; m_pp = 0; m_left = 0; m_req = 0;
    end else begin
      m_kick = wr && addr == 8'h08 && wdata == 32'h4755;
      m_exp  = m_en && tick && m_cnt == 0 && !m_kick;
      m_req  = m_exp && m_sr;
      if (m_exp) m_left = m_len + 1;
      else if (tick && m_left > 0) m_left = m_left - 1;
      if (m_kick) m_cnt = m_reload;
      else if (m_en && tick) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
      if (wr) begin
        if (addr == 8'h04) m_reload = wdata;
        if (addr == 8'h0C) begin m_en = wdata[0]; m_sr = wdata[1]; end
        if (addr == 8'h18) begin
          m_len = int'(wdata[19:0]);
          if (wdata[31:24] == 8'hA5) m_hi = 1;
          if (wdata[31:24] == 8'h5A) m_hi = 0;
          if (wdata[31:24] == 8'hA8) m_pp = 1;
          if (wdata[31:24] == 8'h8A) m_pp = 0;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return m_cnt;
      8'h04: return m_reload;
      8'h0C: return {30'd0, m_sr, m_en};
      8'h18: return {m_hi, m_pp, 10'd0, 20'(m_len)};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      check(pad_out == (m_left > 0 ? m_hi : !m_hi), "R10 pad_out", 32'(pad_out), 32'(m_left > 0 ? m_hi : !m_hi));
      check(pad_oe == (m_pp || m_left > 0), "R8 pad_oe pulse length", 32'(pad_oe), 32'(m_pp || m_left > 0));
      check(rst_req == m_req, "R9 rst_req", 32'(rst_req), 32'(m_req));
      check(rdata == exp_rd(addr), "R6 readback", rdata, exp_rd(addr));
    end
  end

  task automatic drive(bit t, bit w, logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    tick = t; wr = w; addr = a; wdata = d;
  endtask

  task automatic run(int n, int per);
    for (int i = 0; i < n; i++) drive(i % per == 0, 1'b0, addr, 32'd0);
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] expv, string req);
    drive(1'b0, 1'b0, a, 32'd0);
    @(negedge clk);
    check(rdata == expv, req, rdata, expv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pad_out == 1'b1 && pad_oe == 1'b0, "R1 pad idle", {pad_out, pad_oe}, 32'h2);
    rd_chk(8'h18, 32'h0000_00FF, "R1 pulse config");
    rd_chk(8'h0C, 32'h0, "R1 control");
    rd_chk(8'h04, RLD_RST, "R1 reload");
    rd_chk(8'h00, RLD_RST, "R1 counter");
    live = 1'b1;

    // R5 non-key top byte, R2 width taken
    drive(0, 1, 8'h18, 32'h1200_0003);
    rd_chk(8'h18, 32'h0000_0003, "R5 non-key keeps modes");
    // R2 upper bits read zero
    drive(0, 1, 8'h18, 32'hFFFF_FFFF);
    rd_chk(8'h18, 32'h000F_FFFF, "R2 bits 29:20 zero");
    drive(0, 1, 8'h18, 32'h0000_0003);

    // R6 R8 R9 open-drain active-low pulses
    drive(0, 1, 8'h04, 32'd5);
    drive(0, 1, 8'h08, 32'h4755);
    drive(0, 1, 8'h0C, 32'h3);
    drive(0, 0, 8'h00, 0);
    run(60, 2);

    // R3 active high
    drive(0, 1, 8'h18, 32'hA500_0002);
    rd_chk(8'h18, 32'h8000_0002, "R3 level high key");
    run(40, 2);
    // R4 push-pull
    drive(0, 1, 8'h18, 32'hA800_0001);
    rd_chk(8'h18, 32'hC000_0001, "R4 push-pull key");
    drive(0, 0, 8'h00, 0);
    run(40, 3);
    drive(0, 1, 8'h18, 32'h5A00_0001);
    rd_chk(8'h18, 32'h4000_0001, "R3 level low key");
    drive(0, 1, 8'h18, 32'h8A00_0004);
    rd_chk(8'h18, 32'h0000_0004, "R4 open-drain key");

    // R7 wrong key has no effect
    drive(0, 1, 8'h08, 32'h4756);
    drive(0, 0, 8'h00, 0);
    run(20, 2);

    // R7 restart beats expiry: reload 0, tick every cycle
    drive(0, 1, 8'h18, 32'h0000_0000);
    drive(0, 1, 8'h04, 32'd0);
    run(6, 1);
    drive(1, 1, 8'h08, 32'h4755);
    drive(0, 0, 8'h00, 0);
    @(negedge clk);
    check(rst_req == 1'b0, "R7 restart blocks expiry", 32'(rst_req), 32'd0);

    // R11 width change during a pulse, and re-expiry during a pulse
    drive(0, 1, 8'h18, 32'h0000_0006);
    drive(0, 1, 8'h04, 32'd3);
    drive(0, 1, 8'h08, 32'h4755);
    run(9, 2);
    drive(0, 1, 8'h18, 32'h0000_0000);
    drive(0, 0, 8'h00, 0);
    run(30, 2);
    drive(0, 1, 8'h18, 32'h0000_0008);
    drive(0, 0, 8'h00, 0);
    run(40, 2);

    // R9 no request when sysrst disabled
    drive(0, 1, 8'h0C, 32'h1);
    drive(0, 0, 8'h00, 0);
    run(30, 2);

    // R6 disabled counter holds
    drive(0, 1, 8'h0C, 32'h0);
    drive(0, 1, 8'h04, 32'd50);
    drive(0, 1, 8'h08, 32'h4755);
    run(10, 1);
    rd_chk(8'h00, 32'd50, "R6 hold when disabled");

    live = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule